// File: doc/BRIEF.md
# Countdown Alarm with Sticky Pending Interrupt

The block counts down a programmed interval of days, hours, minutes and seconds, one step on each one-second tick. Software loads the interval through a simple register bus, turns counting on with a count-enable bit, and can read the remaining count back at any time. When the count steps from one second to zero while counting is enabled, a sticky pending flag is set. The count then stays at zero until it is reloaded.

The interrupt output is driven only while three things hold at once: the pending flag, the interrupt-enable bit and the count-enable bit. Software clears the flag by writing one to its status bit. Writing zero to the interval register abandons a countdown that is in progress. The one-second tick is an input to the block, which needs it to be a single-cycle pulse in the bus clock domain.

Top module: `countdown_alarm`

## Requirements
- R1: The interval register is at byte offset 0x0C. A write loads seconds from bits [5:0], minutes from [13:8], hours from [20:16] and days from [28:21]. A read returns the remaining count in the same layout, with every other bit zero.
- R2: While count-enable (bit 8 at offset 0x14) is 1 and the count is non-zero, each tick lowers the count by one second. A field that is at zero borrows from the next field and reloads: seconds to 59, minutes to 59, hours to 23, taken from the days. Days cover 0 to 255.
- R3: While count-enable is 0, ticks leave the count unchanged. The count resumes from the held value when count-enable is set again.
- R4: The tick that takes the count from exactly one second to zero while counting is enabled sets the pending flag (bit 0 at offset 0x1C). The count then holds at zero, and later ticks set nothing further.
- R5: Writing 1 to bit 0 at offset 0x1C clears the pending flag. Writing 0 there leaves the flag unchanged.
- R6: The interrupt output is 1 only when the pending flag, interrupt-enable (bit 0 at offset 0x18) and count-enable are all 1.
- R7: Writing 0 to the interval register clears the count, and no expiry follows from it. A write to the interval register in the same cycle as a tick takes precedence, so the written value is held unchanged.
- R8: When a clear write to the status bit and an expiry fall in the same cycle, the pending flag ends up set.
- R9: After reset the count, both enable bits, the pending flag and the interrupt output are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Alarm interrupt request |

## Verification
Two pairs of events can land in the same clock edge. The first is an expiry tick together with a write-one-to-clear of the status bit. The second is a tick together with a write to the interval register. The bench provokes each one by raising sec_tick and bus_wr in the same cycle. For the first pair, the pending flag must read back as set, with the interrupt still asserted. For the second, the interval read back just afterwards must equal the written value exactly, with no decrement applied.

// File: rtl/alarm_pkg.sv
// alarm_pkg: shared field layout, limits and register offsets of the
// countdown alarm. Assumes a byte-addressed bus with 32-bit registers.
package alarm_pkg;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HR_W    = 5;
    localparam int SEC_LSB = 0;
    localparam int MIN_LSB = 8;
    localparam int HR_LSB  = 16;
    localparam int DAY_LSB = 21;

    localparam int SEC_MAX = 59;
    localparam int MIN_MAX = 59;
    localparam int HR_MAX  = 23;

    localparam int OFF_INTERVAL = 'h0C;
    localparam int OFF_CNT_EN   = 'h14;
    localparam int OFF_IRQ_EN   = 'h18;
    localparam int OFF_STATUS   = 'h1C;

    localparam int CNT_EN_BIT   = 8;
    localparam int IRQ_EN_BIT   = 0;
    localparam int PEND_BIT     = 0;
endpackage

// File: rtl/alarm_countdown.sv
// alarm_countdown: mixed-radix down counter (days/hours/minutes/seconds).
// Assumes tick is a one-cycle pulse; a load has priority over a tick.
// expire is high in the cycle whose tick takes the count from 1 s to 0.
module alarm_countdown
    import alarm_pkg::*;
#(
    parameter int DAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SEC_W-1:0]   load_sec,
    input  logic [MIN_W-1:0]   load_min,
    input  logic [HR_W-1:0]    load_hr,
    input  logic [DAY_W-1:0]   load_day,
    input  logic               tick,
    input  logic               run,
    output logic [SEC_W-1:0]   sec,
    output logic [MIN_W-1:0]   min,
    output logic [HR_W-1:0]    hr,
    output logic [DAY_W-1:0]   day,
    output logic               expire
);
    logic [SEC_W-1:0] sec_nx;
    logic [MIN_W-1:0] min_nx;
    logic [HR_W-1:0]  hr_nx;
    logic [DAY_W-1:0] day_nx;
    logic             nonzero, at_one, step;

    // Decode the count and decide whether this cycle steps it.
    always_comb begin
        nonzero = (sec != '0) || (min != '0) || (hr != '0) || (day != '0);
        at_one  = (sec == SEC_W'(1)) && (min == '0) && (hr == '0) && (day == '0);
        step    = tick && run && nonzero && !load;
        expire  = step && at_one;
    end

    // One-second decrement with borrow chain seconds -> minutes -> hours -> days.
    always_comb begin
        sec_nx = sec;
        min_nx = min;
        hr_nx  = hr;
        day_nx = day;
        if (sec != '0) begin
            sec_nx = sec - SEC_W'(1);
        end else begin
            sec_nx = SEC_W'(SEC_MAX);
            if (min != '0) begin
                min_nx = min - MIN_W'(1);
            end else begin
                min_nx = MIN_W'(MIN_MAX);
                if (hr != '0) begin
                    hr_nx = hr - HR_W'(1);
                end else begin
                    hr_nx  = HR_W'(HR_MAX);
                    day_nx = day - DAY_W'(1);
                end
            end
        end
    end

    // Count register: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
            min <= '0;
            hr  <= '0;
            day <= '0;
        end else if (load) begin
            sec <= load_sec;
            min <= load_min;
            hr  <= load_hr;
            day <= load_day;
        end else if (step) begin
            sec <= sec_nx;
            min <= min_nx;
            hr  <= hr_nx;
            day <= day_nx;
        end
    end

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable({day, hr, min, sec}));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire) |=> ({day, hr, min, sec} == '0));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load) |=> (sec == $past(load_sec) && day == $past(load_day)));
endmodule

// File: rtl/alarm_pending.sv
// alarm_pending: sticky pending flag. set has priority over clr.
// Assumes both inputs are synchronous one-cycle requests.
module alarm_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    // Sticky flag update with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    // R8
    set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set) |=> (pend));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend));
endmodule

// File: rtl/countdown_alarm.sv
// countdown_alarm: register front end of the countdown alarm. Decodes the
// interval, count-enable, interrupt-enable and write-one-to-clear status
// registers and gates the interrupt. Assumes sec_tick is a one-cycle pulse
// in the clk domain and reads are combinational.
module countdown_alarm
    import alarm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int DAY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_INTERVAL = ADDR_W'(OFF_INTERVAL);
    localparam logic [ADDR_W-1:0] A_CNT_EN   = ADDR_W'(OFF_CNT_EN);
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = ADDR_W'(OFF_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFF_STATUS);

    logic             wr_interval, wr_cnt_en, wr_irq_en, wr_status;
    logic             cnt_en, irq_en, pend, expire;
    logic [SEC_W-1:0] sec;
    logic [MIN_W-1:0] min;
    logic [HR_W-1:0]  hr;
    logic [DAY_W-1:0] day;

    // Address decode of write strobes.
    always_comb begin
        wr_interval = bus_wr && (bus_addr == A_INTERVAL);
        wr_cnt_en   = bus_wr && (bus_addr == A_CNT_EN);
        wr_irq_en   = bus_wr && (bus_addr == A_IRQ_EN);
        wr_status   = bus_wr && (bus_addr == A_STATUS);
    end

    // Enable bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en <= 1'b0;
            irq_en <= 1'b0;
        end else begin
            if (wr_cnt_en) cnt_en <= bus_wdata[CNT_EN_BIT];
            if (wr_irq_en) irq_en <= bus_wdata[IRQ_EN_BIT];
        end
    end

    alarm_countdown #(.DAY_W(DAY_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_interval),
        .load_sec (bus_wdata[SEC_LSB +: SEC_W]),
        .load_min (bus_wdata[MIN_LSB +: MIN_W]),
        .load_hr  (bus_wdata[HR_LSB  +: HR_W]),
        .load_day (bus_wdata[DAY_LSB +: DAY_W]),
        .tick     (sec_tick),
        .run      (cnt_en),
        .sec      (sec),
        .min      (min),
        .hr       (hr),
        .day      (day),
        .expire   (expire)
    );

    alarm_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (wr_status && bus_wdata[PEND_BIT]),
        .pend  (pend)
    );

    // Interrupt gate: pending, interrupt enable and count enable together.
    always_comb irq_out = pend && irq_en && cnt_en;

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_INTERVAL: begin
                bus_rdata[SEC_LSB +: SEC_W] = sec;
                bus_rdata[MIN_LSB +: MIN_W] = min;
                bus_rdata[HR_LSB  +: HR_W]  = hr;
                bus_rdata[DAY_LSB +: DAY_W] = day;
            end
            A_CNT_EN: bus_rdata[CNT_EN_BIT] = cnt_en;
            A_IRQ_EN: bus_rdata[IRQ_EN_BIT] = irq_en;
            A_STATUS: bus_rdata[PEND_BIT]   = pend;
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend || !cnt_en) |-> (!irq_out));

    // R4
    pend_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire) |=> (pend));
endmodule

// File: tb/countdown_alarm_bench.sv
module countdown_alarm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] rv;

    localparam logic [4:0] A_IV = 5'h0C, A_CE = 5'h14, A_IE = 5'h18, A_ST = 5'h1C;

    always #4 clk = ~clk;

    countdown_alarm u_countdown_alarm (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] pack(int d, int h, int m, int s);
        return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus write, optionally with a tick in the same cycle.
    task automatic wr(logic [4:0] a, logic [31:0] d, logic with_tick = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = with_tick;
        @(negedge clk);
        bus_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset;
        rd(A_IV, rv); chk("R9 interval", rv, 0);
        rd(A_CE, rv); chk("R9 cnt_en", rv, 0);
        rd(A_ST, rv); chk("R9 pending", rv, 0);
        chk("R9 irq", 32'(irq_out), 0);
    endtask

    task automatic t_borrow;
        wr(A_IV, pack(1, 0, 0, 0)); wr(A_CE, 32'h100);
        rd(A_IV, rv); chk("R1 readback", rv, pack(1, 0, 0, 0));
        tick(); rd(A_IV, rv); chk("R2 day borrow", rv, pack(0, 23, 59, 59));
        wr(A_IV, pack(255, 0, 0, 0)); tick();
        rd(A_IV, rv); chk("R2 day 255", rv, pack(254, 23, 59, 59));
        wr(A_IV, pack(0, 3, 0, 0)); tick();
        rd(A_IV, rv); chk("R2 hour borrow", rv, pack(0, 2, 59, 59));
        wr(A_IV, pack(0, 0, 5, 0)); tick();
        rd(A_IV, rv); chk("R2 minute borrow", rv, pack(0, 0, 4, 59));
    endtask

    task automatic t_freeze;
        wr(A_CE, 0); tick(3);
        rd(A_IV, rv); chk("R3 frozen", rv, pack(0, 0, 4, 59));
        wr(A_CE, 32'h100); tick();
        rd(A_IV, rv); chk("R3 resume", rv, pack(0, 0, 4, 58));
    endtask

    task automatic t_expire;
        wr(A_IE, 1); wr(A_IV, pack(0, 0, 0, 2)); tick();
        rd(A_ST, rv); chk("R4 not yet", rv, 0);
        tick(); rd(A_ST, rv); chk("R4 pending set", rv, 1);
        chk("R6 irq on", 32'(irq_out), 1);
        rd(A_IV, rv); chk("R4 at zero", rv, 0);
        tick(2); rd(A_IV, rv); chk("R4 holds zero", rv, 0);
    endtask

    task automatic t_w1c;
        wr(A_ST, 0); rd(A_ST, rv); chk("R5 write 0 keeps", rv, 1);
        wr(A_IE, 0); chk("R6 irq_en off", 32'(irq_out), 0);
        wr(A_IE, 1); wr(A_CE, 0); chk("R6 cnt_en off", 32'(irq_out), 0);
        wr(A_CE, 32'h100); chk("R6 irq back", 32'(irq_out), 1);
        wr(A_ST, 1); rd(A_ST, rv); chk("R5 write 1 clears", rv, 0);
        tick(2); rd(A_ST, rv); chk("R4 no re-set", rv, 0);
    endtask

    task automatic t_clear_interval;
        wr(A_IV, pack(0, 0, 0, 3)); wr(A_IV, 0);
        rd(A_IV, rv); chk("R7 zero clears", rv, 0);
        tick(4); rd(A_ST, rv); chk("R7 no expiry", rv, 0);
        wr(A_IV, pack(0, 1, 2, 3), 1'b1);
        rd(A_IV, rv); chk("R7 write beats tick", rv, pack(0, 1, 2, 3));
    endtask

    task automatic t_same_cycle;
        wr(A_IV, pack(0, 0, 0, 1)); tick();
        rd(A_ST, rv); chk("R8 setup", rv, 1);
        wr(A_IV, pack(0, 0, 0, 1));
        wr(A_ST, 1, 1'b1);
        rd(A_ST, rv); chk("R8 set beats clear", rv, 1);
        chk("R8 irq", 32'(irq_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_borrow();
        t_freeze();
        t_expire();
        t_w1c();
        t_clear_interval();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule